// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a small on-chip RAM with one write port and one read port. Both ports work on one shared bit array. Each port picks its own aspect ratio, so a producer can write narrow words while a consumer reads wide words, or the other way round.

Two families of shapes exist:

- **Plain family:** shapes that hold 4096 bits in total.
- **Lane-extended family:** shapes that hold 4608 bits in total, with nine-bit lanes. The ninth bit of each lane is plain storage, for example for a check bit or a user tag. The block computes nothing over it.

An address on the narrow side selects a lane inside a wide word. The low address bits pick the lane and the high address bits pick the word. Reads are synchronous and have an output register that the reset clears. The storage itself is never cleared.

Top module: `msdp_ram`

## Requirements
- R1: In the plain family the legal port widths are 1, 2, 4, 8, 16 and 32. Each gives a depth of 4096/width, and every address from 0 to depth-1 reaches its own location. For the 8-bit write and 32-bit read pair, write address 511 and read address 127 are the last ones.
- R2: In the lane-extended family the legal widths are 9, 18 and 36, with depth 4608/width. Every bit of a nine-bit lane is stored and read back unchanged, including bit 8.
- R3: A pair of widths is accepted only when both widths come from the same family. Any other pair stops elaboration with an error. The package function `pair_ok` gives this same verdict.
- R4: The mapping between narrow and wide is little-endian. Narrow address n sits in wide word n >> log2(ratio), in lane n mod ratio. Lane k occupies bits [k*L +: L] of the wide word, where L is the narrow width. For example, bytes 0x11, 0x22, 0x33 and 0x44 written at byte addresses 4 to 7 read back as word 1 = 0x44332211.
- R5: A write changes only the bits that its own width covers. The other lanes of the same wide word keep their contents.
- R6: A read has a latency of one clock. The address presented before an edge is looked up at that edge, and rd_data shows the result from then until the next edge.
- R7: A read and a write may hit the same location at the same edge. The read then returns the contents from before that write, and the next read returns the new contents.
- R8: While rst is high at a rising edge, rd_data becomes zero. The stored contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high clear of the read output |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | log2(total/WR_W) | Write address in write-port units |
| wr_data | input | WR_W | Write data |
| rd_addr | input | log2(total/RD_W) | Read address in read-port units |
| rd_data | output | RD_W | Registered read data |

## Verification
Each write lands at the rising edge where wr_en is sampled high. Each read result appears one edge after its address is applied. The bench drives every input on a falling edge and reads rd_data on the following falling edge, half a period after the edge that produced it.

The latency check also samples rd_data just after the new address is applied, before the next edge, and expects the old value there. The collision check expects old data on the first falling edge and new data on the second.

// File: rtl/msdp_pkg.sv
package msdp_pkg;

  localparam int PLAIN_BITS = 4096;
  localparam int LANE_BITS  = 4608;

  function automatic bit is_plain(input int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
  endfunction

  function automatic bit is_laned(input int w);
    return (w == 9) || (w == 18) || (w == 36);
  endfunction

  function automatic bit pair_ok(input int a, input int b);
    return (is_plain(a) && is_plain(b)) || (is_laned(a) && is_laned(b));
  endfunction

  function automatic int total_bits(input int w);
    return is_laned(w) ? LANE_BITS : PLAIN_BITS;
  endfunction

endpackage

// File: rtl/msdp_lane.sv
module msdp_lane #(
  parameter int LANE = 8,
  parameter int DW   = 128,
  parameter int IW   = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [LANE-1:0] wdata,
  input  logic [IW-1:0]   ridx,
  output logic [LANE-1:0] rq
);

  logic [LANE-1:0] mem [DW];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rq <= '0;
    else     rq <= mem[ridx];
  end

  // R5: a written lane holds the written value after the edge
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(widx)] == $past(wdata));

  // R7: a colliding read must not see the value being written
  a_r7_old_data: assert property (@(posedge clk) disable iff (rst)
    (we && ridx == widx && wdata != mem[widx]) |=> rq != $past(wdata));

endmodule

// File: rtl/msdp_wr_decode.sv
module msdp_wr_decode #(
  parameter int NLANE   = 4,
  parameter int LSEL    = 2,
  parameter int WA      = 9,
  parameter int IW      = 7,
  parameter bit WIDE_WR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WA-1:0]    wr_addr,
  output logic [IW-1:0]    widx,
  output logic [NLANE-1:0] lane_we
);

  if (WIDE_WR) begin : g_wide
    assign widx    = wr_addr;
    assign lane_we = {NLANE{wr_en}};
  end else begin : g_narrow
    assign widx = wr_addr[WA-1:LSEL];
    always_comb begin
      lane_we = '0;
      lane_we[wr_addr[LSEL-1:0]] = wr_en;
    end
  end

  // R5: a narrow write touches exactly one lane, a wide one touches all
  a_r5_lane_count: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $countones(lane_we) == (WIDE_WR ? NLANE : 1));

  // R5: no lane changes when no write is asked for
  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> lane_we == '0);

endmodule

// File: rtl/msdp_rd_select.sv
module msdp_rd_select #(
  parameter int NLANE   = 4,
  parameter int LSEL    = 2,
  parameter int LANE    = 8,
  parameter int RA      = 7,
  parameter int IW      = 7,
  parameter int RD_W    = 32,
  parameter bit WIDE_RD = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [RA-1:0]         rd_addr,
  output logic [IW-1:0]         ridx,
  input  logic [NLANE*LANE-1:0] lane_q,
  output logic [RD_W-1:0]       rd_data
);

  if (WIDE_RD) begin : g_wide
    assign ridx    = rd_addr;
    assign rd_data = lane_q;
  end else begin : g_narrow
    logic [LSEL-1:0] sel_q;
    assign ridx = rd_addr[RA-1:LSEL];
    always_ff @(posedge clk) begin
      if (rst) sel_q <= '0;
      else     sel_q <= rd_addr[LSEL-1:0];
    end
    assign rd_data = lane_q[sel_q*LANE +: LANE];
  end

  // R6: same address and no write in between means the output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == $past(rd_addr) && !$past(wr_en) && !$past(rst)) |=> $stable(rd_data));

endmodule

// File: rtl/msdp_ram.sv
module msdp_ram #(
  parameter int WR_W = 8,
  parameter int RD_W = 32,
  localparam int TOTAL = msdp_pkg::total_bits(WR_W),
  localparam int WA    = $clog2(TOTAL / WR_W),
  localparam int RA    = $clog2(TOTAL / RD_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [WA-1:0]   wr_addr,
  input  logic [WR_W-1:0] wr_data,
  input  logic [RA-1:0]   rd_addr,
  output logic [RD_W-1:0] rd_data
);

  localparam bit WIDE_WR = (WR_W >= RD_W);
  localparam int WIDE    = WIDE_WR ? WR_W : RD_W;
  localparam int LANE    = WIDE_WR ? RD_W : WR_W;
  localparam int NLANE   = WIDE / LANE;
  localparam int LSEL    = $clog2(NLANE);
  localparam int DW      = TOTAL / WIDE;
  localparam int IW      = $clog2(DW);

  // R3: shape pair legality is settled at elaboration
  if (!msdp_pkg::pair_ok(WR_W, RD_W)) begin : g_bad_shape
    $error("msdp_ram: widths %0d and %0d are not a legal same-family pair", WR_W, RD_W);
  end

  logic [IW-1:0]         widx;
  logic [IW-1:0]         ridx;
  logic [NLANE-1:0]      lane_we;
  logic [NLANE*LANE-1:0] lane_q;

  msdp_wr_decode #(
    .NLANE(NLANE), .LSEL(LSEL), .WA(WA), .IW(IW), .WIDE_WR(WIDE_WR)
  ) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .widx(widx), .lane_we(lane_we)
  );

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic [LANE-1:0] wd;
    if (WIDE_WR) begin : g_slice
      assign wd = wr_data[j*LANE +: LANE];
    end else begin : g_bcast
      assign wd = wr_data;
    end
    msdp_lane #(.LANE(LANE), .DW(DW), .IW(IW)) u_lane (
      .clk(clk), .rst(rst), .we(lane_we[j]), .widx(widx), .wdata(wd),
      .ridx(ridx), .rq(lane_q[j*LANE +: LANE])
    );
  end

  msdp_rd_select #(
    .NLANE(NLANE), .LSEL(LSEL), .LANE(LANE), .RA(RA), .IW(IW),
    .RD_W(RD_W), .WIDE_RD(!WIDE_WR || NLANE == 1)
  ) u_rd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_addr(rd_addr), .ridx(ridx),
    .lane_q(lane_q), .rd_data(rd_data)
  );

endmodule

// File: tb/tb_msdp_ram.sv
module tb_msdp_ram;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // narrow write (8) / wide read (32), plain family
  logic        wen_a = 1'b0;
  logic [8:0]  wad_a = '0;
  logic [7:0]  wdt_a = '0;
  logic [6:0]  rad_a = '0;
  logic [31:0] rdt_a;

  // wide write (36) / narrow read (9), lane-extended family
  logic        wen_b = 1'b0;
  logic [6:0]  wad_b = '0;
  logic [35:0] wdt_b = '0;
  logic [8:0]  rad_b = '0;
  logic [8:0]  rdt_b;

  msdp_ram #(.WR_W(8), .RD_W(32)) dut (
    .clk(clk), .rst(rst), .wr_en(wen_a), .wr_addr(wad_a), .wr_data(wdt_a),
    .rd_addr(rad_a), .rd_data(rdt_a)
  );

  msdp_ram #(.WR_W(36), .RD_W(9)) dut_p (
    .clk(clk), .rst(rst), .wr_en(wen_b), .wr_addr(wad_b), .wr_data(wdt_b),
    .rd_addr(rad_b), .rd_data(rdt_b)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_a(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    wen_a = 1'b1; wad_a = a; wdt_a = d;
    @(negedge clk);
    wen_a = 1'b0;
  endtask

  task automatic rd_a(input logic [6:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    rad_a = a;
    @(negedge clk);
    chk(tag, 64'(rdt_a), 64'(exp));
  endtask

  task automatic wr_b(input logic [6:0] a, input logic [35:0] d);
    @(negedge clk);
    wen_b = 1'b1; wad_b = a; wdt_b = d;
    @(negedge clk);
    wen_b = 1'b0;
  endtask

  task automatic rd_b(input logic [8:0] a, input string tag, input logic [8:0] exp);
    @(negedge clk);
    rad_b = a;
    @(negedge clk);
    chk(tag, 64'(rdt_b), 64'(exp));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R8 reset output narrow-write port", 64'(rdt_a), 64'h0);
    chk("R8 reset output narrow-read port", 64'(rdt_b), 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_family();
    chk("R3 plain pair 8/32 accepted", 64'(msdp_pkg::pair_ok(8, 32)), 64'h1);
    chk("R3 laned pair 36/9 accepted", 64'(msdp_pkg::pair_ok(36, 9)), 64'h1);
    chk("R3 mixed pair 9/32 rejected", 64'(msdp_pkg::pair_ok(9, 32)), 64'h0);
    chk("R3 odd width 12 rejected", 64'(msdp_pkg::pair_ok(12, 12)), 64'h0);
  endtask

  task automatic t_le_map();
    wr_a(9'd4, 8'h11); wr_a(9'd5, 8'h22); wr_a(9'd6, 8'h33); wr_a(9'd7, 8'h44);
    wr_a(9'd0, 8'hA0); wr_a(9'd1, 8'hB1); wr_a(9'd2, 8'hC2); wr_a(9'd3, 8'hD3);
    rd_a(7'd1, "R4 bytes 4..7 into word 1", 32'h44332211);
    rd_a(7'd0, "R4 bytes 0..3 into word 0", 32'hD3C2B1A0);
  endtask

  task automatic t_partial();
    wr_a(9'd5, 8'hAA);
    rd_a(7'd1, "R5 one byte rewritten", 32'h4433AA11);
    rd_a(7'd0, "R5 neighbour word untouched", 32'hD3C2B1A0);
  endtask

  task automatic t_collision();
    @(negedge clk);
    rad_a = 7'd1;
    @(negedge clk);
    wen_a = 1'b1; wad_a = 9'd4; wdt_a = 8'h55;
    @(negedge clk);
    wen_a = 1'b0;
    chk("R7 colliding read gives old data", 64'(rdt_a), 64'h4433AA11);
    @(negedge clk);
    chk("R7 following read gives new data", 64'(rdt_a), 64'h4433AA55);
  endtask

  task automatic t_latency();
    @(negedge clk);
    rad_a = 7'd0;
    #2;
    chk("R6 output holds before edge", 64'(rdt_a), 64'h4433AA55);
    @(negedge clk);
    chk("R6 output updated one edge later", 64'(rdt_a), 64'hD3C2B1A0);
  endtask

  task automatic t_edge();
    wr_a(9'd508, 8'h01); wr_a(9'd509, 8'h02); wr_a(9'd510, 8'h03); wr_a(9'd511, 8'hC3);
    rd_a(7'd127, "R1 last addresses 511 and 127", 32'hC3030201);
    rd_a(7'd1, "R1 low word kept", 32'h4433AA55);
  endtask

  task automatic t_laned();
    wr_b(7'd0, {9'h1FF, 9'h100, 9'h0F0, 9'h1A5});
    wr_b(7'd127, {9'h001, 9'h0AA, 9'h155, 9'h1C0});
    rd_b(9'd0, "R4 lane 0 of wide word 0", 9'h1A5);
    rd_b(9'd1, "R4 lane 1 of wide word 0", 9'h0F0);
    rd_b(9'd2, "R2 ninth bit alone kept", 9'h100);
    rd_b(9'd3, "R2 full nine-bit lane", 9'h1FF);
    rd_b(9'd508, "R1 laned word 127 lane 0", 9'h1C0);
    rd_b(9'd511, "R1 laned last address 511", 9'h001);
  endtask

  task automatic t_reset_keep();
    @(negedge clk);
    rad_a = 7'd1;
    rad_b = 9'd3;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 output cleared by reset", 64'(rdt_a), 64'h0);
    chk("R8 laned output cleared by reset", 64'(rdt_b), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 contents survive reset", 64'(rdt_a), 64'h4433AA55);
    chk("R8 laned contents survive reset", 64'(rdt_b), 64'h1FF);
  endtask

  initial begin
    t_reset();
    t_family();
    t_le_map();
    t_partial();
    t_collision();
    t_latency();
    t_edge();
    t_laned();
    t_reset_keep();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule